// File: doc/BRIEF.md
# Five-Source Prioritised Interrupt Controller

This block sits next to a small 8-bit processor core and decides which of five interrupt request lines the core takes. The highest-priority line is a non-maskable request, which is armed by a rising edge. Next comes an edge-latched request. Below that are two level requests, each with its own mask, and a general external level request that has no built-in vector. The core pulses a sampling strobe at each point where it may take an interrupt. On the cycle after that strobe, the block reports the winner as a one-cycle accept pulse. The pulse carries a 16-bit service address, or a flag that says the external device must supply the address.

Software controls the block through three strobes: global enable on, global enable off, and a packed mask write taken from an 8-bit data value. It reads back a packed 8-bit status byte. This byte shows the masks, the global enable, the state of the three numbered requests and a serial input pin. Accepting any interrupt turns the global enable off, so a service routine runs unnested until it turns the enable back on.

Top module: `irq5_ctrl`

## Requirements
- R1: After reset the global enable is 0, all three mask bits are 1, the edge latch is empty and no accept pulse is given; with all inputs low the status byte reads 07h.
- R2: A pulse on `en_set_i` sets the global enable and a pulse on `en_clr_i` clears it; if both arrive in one cycle the enable ends up cleared.
- R3: A mask write with data bit 3 = 1 loads data bits 2:0 into the masks (bit 0 for the low level source, bit 1 for the high level source, bit 2 for the edge source; 1 blocks). A mask write with bit 3 = 0 leaves the masks unchanged.
- R4: Requests are only considered in a cycle where `sample_i` is high; `take_o` is high for exactly the cycle after that sampling edge.
- R5: When several sources qualify, the winner is chosen in the fixed order non-maskable, edge, high level, low level, external.
- R6: The service addresses are 0024h (non-maskable), 003Ch (edge), 0034h (high level), 002Ch (low level); the external source gives `no_vector_o` = 1 with `vector_o` = 0000h.
- R7: The edge, level and external sources need the global enable. Any accept clears the global enable, and this takes priority over an `en_set_i` pulse in the same cycle.
- R8: The non-maskable source ignores both the global enable and the masks. It is taken only while its line is high and after a rising edge since its last accept. A line held high is not taken twice.
- R9: A rising edge on `edge_i` is latched whatever the mask state and is held after the line drops. The latch empties when that source is accepted, or on a mask write with data bit 4 = 1, whatever bit 3 is.
- R10: The two level sources and the external source are taken only if their line is high in the sampling cycle; a level that has dropped again is not taken.
- R11: The status byte holds: bits 2:0 the masks (low level, high level, edge), bit 3 the global enable, bit 4 the low level line, bit 5 the high level line, bit 6 the edge latch, and bit 7 `serial_in_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 1 | Instruction-boundary sampling strobe |
| en_set_i | input | 1 | Turn global enable on |
| en_clr_i | input | 1 | Turn global enable off |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Packed mask write value |
| nmi_i | input | 1 | Non-maskable request, armed by rising edge |
| edge_i | input | 1 | Edge-latched request |
| lvl_a_i | input | 1 | High-priority level request |
| lvl_b_i | input | 1 | Low-priority level request |
| ext_i | input | 1 | External level request without vector |
| serial_in_i | input | 1 | Serial data pin shown in status bit 7 |
| status_o | output | 8 | Packed status byte |
| take_o | output | 1 | Accept pulse |
| vector_o | output | 16 | Service address of the accepted source |
| no_vector_o | output | 1 | Accepted source has no internal address |

## Verification
The hardest states to reach from the ports are the stored request states. One is an edge latch that holds a request after its line has dropped, while it is still masked. Another is a non-maskable line that stays high after it has been accepted. To reach them, the stimulus pulses `edge_i` between sampling strobes and shows the latch through status bit 6. It also samples a second time with the non-maskable line still held high. A sweep loads every mask pattern, sets the enable and drives every one of the 32 request combinations. It then checks the winner, its address and the status byte that results.

// File: rtl/irq5_pkg.sv
package irq5_pkg;
    localparam int NSRC    = 5;
    localparam int DATA_W  = 8;
    localparam int NMASK   = 3;
    // source indices, index 0 is the highest priority
    localparam int SRC_NMI = 0;
    localparam int SRC_EDG = 1;
    localparam int SRC_LVA = 2;
    localparam int SRC_LVB = 3;
    localparam int SRC_EXT = 4;
    // mask write control bits
    localparam int WR_LOAD_BIT  = 3;
    localparam int WR_FLUSH_BIT = 4;
endpackage

// File: rtl/irq5_edge_catch.sv
module irq5_edge_catch (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic clr_i,
    output logic pend_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } ec_st_t;

    ec_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
        if (clr_i)
            st_d.pend = 1'b0;
        // a fresh edge in the clearing cycle is kept
        if (level_i && !st_q.prev)
            st_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/irq5_prio.sv
module irq5_prio #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    always_comb begin
        grant_o = '0;
        any_o   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !any_o) begin
                grant_o[i] = 1'b1;
                any_o      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq5_vec_sel.sv
module irq5_vec_sel #(
    parameter int                    N       = 5,
    parameter int                    AW      = 16,
    parameter logic [N-1:0][AW-1:0]  VEC_TAB = '0,
    parameter logic [N-1:0]          HAS_VEC = '1
) (
    input  logic [N-1:0]  grant_i,
    output logic [AW-1:0] vector_o,
    output logic          no_vector_o
);
    always_comb begin
        vector_o = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_i[i] && HAS_VEC[i])
                vector_o = vector_o | VEC_TAB[i];
        end
        no_vector_o = |(grant_i & ~HAS_VEC);
    end
endmodule

// File: rtl/irq5_ctrl.sv
module irq5_ctrl #(
    parameter int            AW       = 16,
    parameter logic [AW-1:0] VEC_NMI  = 16'h0024,
    parameter logic [AW-1:0] VEC_EDG  = 16'h003C,
    parameter logic [AW-1:0] VEC_LVA  = 16'h0034,
    parameter logic [AW-1:0] VEC_LVB  = 16'h002C
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sample_i,
    input  logic                        en_set_i,
    input  logic                        en_clr_i,
    input  logic                        mask_wr_i,
    input  logic [irq5_pkg::DATA_W-1:0] mask_wdata_i,
    input  logic                        nmi_i,
    input  logic                        edge_i,
    input  logic                        lvl_a_i,
    input  logic                        lvl_b_i,
    input  logic                        ext_i,
    input  logic                        serial_in_i,
    output logic [irq5_pkg::DATA_W-1:0] status_o,
    output logic                        take_o,
    output logic [AW-1:0]               vector_o,
    output logic                        no_vector_o
);
    import irq5_pkg::*;

    localparam int NLATCH = 2;
    localparam logic [NSRC-1:0][AW-1:0] VEC_TAB =
        {{AW{1'b0}}, VEC_LVB, VEC_LVA, VEC_EDG, VEC_NMI};
    localparam logic [NSRC-1:0] HAS_VEC = ~(NSRC'(1) << SRC_EXT);

    typedef struct packed {
        logic             gie;
        logic [NMASK-1:0] mask;   // [0] low level, [1] high level, [2] edge
        logic             take;
        logic             novec;
        logic [AW-1:0]    vec;
    } st_t;

    st_t st_d, st_q;

    logic [NLATCH-1:0] latch_in, latch_clr, latch_pend;
    logic [NSRC-1:0]   elig, req, grant;
    logic              any_win;
    logic [AW-1:0]     win_vec;
    logic              win_novec;
    logic              flush_edge;
    logic              unused_wdata;

    assign unused_wdata = ^mask_wdata_i[DATA_W-1:WR_FLUSH_BIT+1];

    // latch 0 arms the non-maskable source, latch 1 holds the edge source
    assign latch_in   = {edge_i, nmi_i};
    assign flush_edge = mask_wr_i && mask_wdata_i[WR_FLUSH_BIT];
    assign latch_clr  = {grant[SRC_EDG] | flush_edge, grant[SRC_NMI]};

    genvar g;
    generate
        for (g = 0; g < NLATCH; g++) begin : g_latch
            irq5_edge_catch u_catch (
                .clk     (clk),
                .rst_n   (rst_n),
                .level_i (latch_in[g]),
                .clr_i   (latch_clr[g]),
                .pend_o  (latch_pend[g])
            );
        end
    endgenerate

    always_comb begin
        elig          = '0;
        elig[SRC_NMI] = nmi_i && latch_pend[0];
        elig[SRC_EDG] = st_q.gie && !st_q.mask[2] && latch_pend[1];
        elig[SRC_LVA] = st_q.gie && !st_q.mask[1] && lvl_a_i;
        elig[SRC_LVB] = st_q.gie && !st_q.mask[0] && lvl_b_i;
        elig[SRC_EXT] = st_q.gie && ext_i;
        req           = sample_i ? elig : '0;
    end

    irq5_prio #(.N(NSRC)) u_prio (
        .req_i   (req),
        .grant_o (grant),
        .any_o   (any_win)
    );

    irq5_vec_sel #(
        .N       (NSRC),
        .AW      (AW),
        .VEC_TAB (VEC_TAB),
        .HAS_VEC (HAS_VEC)
    ) u_vec (
        .grant_i     (grant),
        .vector_o    (win_vec),
        .no_vector_o (win_novec)
    );

    always_comb begin
        st_d       = st_q;
        st_d.take  = any_win;
        st_d.vec   = win_vec;
        st_d.novec = win_novec;
        if (mask_wr_i && mask_wdata_i[WR_LOAD_BIT])
            st_d.mask = mask_wdata_i[NMASK-1:0];
        if (en_set_i)
            st_d.gie = 1'b1;
        if (en_clr_i)
            st_d.gie = 1'b0;
        if (any_win)
            st_d.gie = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.gie   <= 1'b0;
            st_q.mask  <= '1;
            st_q.take  <= 1'b0;
            st_q.novec <= 1'b0;
            st_q.vec   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o    = {serial_in_i, latch_pend[1], lvl_a_i, lvl_b_i,
                          st_q.gie, st_q.mask};
    assign take_o      = st_q.take;
    assign vector_o    = st_q.vec;
    assign no_vector_o = st_q.novec;
endmodule

// File: rtl/irq5_ctrl_chk.sv
module irq5_ctrl_chk #(
    parameter int            AW      = 16,
    parameter logic [AW-1:0] VEC_NMI = 16'h0024
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sample_i,
    input logic          en_clr_i,
    input logic          mask_wr_i,
    input logic [7:0]    mask_wdata_i,
    input logic [7:0]    status_o,
    input logic          take_o,
    input logic [AW-1:0] vector_o,
    input logic          no_vector_o
);
    assert_take_after_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(sample_i));

    assert_accept_clears_gie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !status_o[3]);

    assert_maskable_needs_gie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vector_o != VEC_NMI) |-> $past(status_o[3]));

    assert_novec_only_on_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        no_vector_o |-> (take_o && vector_o == '0));

    assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mask_wr_i && mask_wdata_i[3]) |-> status_o[2:0] == $past(mask_wdata_i[2:0]));

    assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mask_wr_i && mask_wdata_i[3]) |-> $stable(status_o[2:0]));

    assert_disable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_clr_i) |-> !status_o[3]);
endmodule

bind irq5_ctrl irq5_ctrl_chk #(.AW(AW), .VEC_NMI(VEC_NMI)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_i     (sample_i),
    .en_clr_i     (en_clr_i),
    .mask_wr_i    (mask_wr_i),
    .mask_wdata_i (mask_wdata_i),
    .status_o     (status_o),
    .take_o       (take_o),
    .vector_o     (vector_o),
    .no_vector_o  (no_vector_o)
);

// File: tb/test_irq5_ctrl.sv
module test_irq5_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample = 1'b0, en_set = 1'b0, en_clr = 1'b0, mwr = 1'b0;
    logic [7:0] mdata = 8'h00;
    logic nmi = 1'b0, edg = 1'b0, lva = 1'b0, lvb = 1'b0, ext = 1'b0, sin = 1'b0;
    logic [7:0]  status;
    logic        take, novec;
    logic [15:0] vec;
    int n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    irq5_ctrl i_irq5_ctrl (
        .clk (clk), .rst_n (rst_n), .sample_i (sample), .en_set_i (en_set),
        .en_clr_i (en_clr), .mask_wr_i (mwr), .mask_wdata_i (mdata),
        .nmi_i (nmi), .edge_i (edg), .lvl_a_i (lva), .lvl_b_i (lvb),
        .ext_i (ext), .serial_in_i (sin), .status_o (status), .take_o (take),
        .vector_o (vec), .no_vector_o (novec)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic mask_write(input logic [7:0] v);
        mwr = 1'b1; mdata = v; tick(); mwr = 1'b0; mdata = 8'h00;
    endtask

    task automatic pulse_en();
        en_set = 1'b1; tick(); en_set = 1'b0;
    endtask

    task automatic do_sample();
        sample = 1'b1; tick(); sample = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); tick(); tick();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 status", status, 8'h07);
        chk("R1 take", take, 0);
        chk("R1 vector", vec, 0);

        // R11 packing of live lines and serial pin
        sin = 1'b1; lva = 1'b1; lvb = 1'b1; #1;
        chk("R11 status", status, 8'hB7);
        sin = 1'b0; lva = 1'b0; lvb = 1'b0;
        tick();

        // R2 enable set/clear
        pulse_en();
        chk("R2 set", status[3], 1);
        en_clr = 1'b1; tick(); en_clr = 1'b0;
        chk("R2 clear", status[3], 0);
        en_set = 1'b1; en_clr = 1'b1; tick(); en_set = 1'b0; en_clr = 1'b0;
        chk("R2 both", status[3], 0);

        // R3 mask load and ignore without bit 3
        mask_write(8'h0A);
        chk("R3 load", status[2:0], 3'b010);
        mask_write(8'h05);
        chk("R3 no load", status[2:0], 3'b010);

        // R4 sampling only at strobe, one-cycle pulse; R6 external
        mask_write(8'h08);
        pulse_en();
        ext = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R4 no strobe", take, 0);
        end
        do_sample();
        chk("R4 take", take, 1);
        chk("R6 ext novec", novec, 1);
        chk("R6 ext vec", vec, 16'h0000);
        tick();
        chk("R4 single pulse", take, 0);

        // R7 gie off blocks; accept beats en_set
        do_sample();
        chk("R7 blocked", take, 0);
        pulse_en();
        en_set = 1'b1; sample = 1'b1; tick(); en_set = 1'b0; sample = 1'b0;
        chk("R7 take", take, 1);
        chk("R7 gie cleared", status[3], 0);
        ext = 1'b0;

        // R8 non-maskable, one accept per rise, gie is 0 here
        nmi = 1'b1; tick();
        do_sample();
        chk("R8 take", take, 1);
        chk("R8 vec", vec, 16'h0024);
        do_sample();
        chk("R8 held no retake", take, 0);
        nmi = 1'b0; tick(); nmi = 1'b1; tick();
        do_sample();
        chk("R8 retake", take, 1);
        nmi = 1'b0; tick();

        // R9 edge latch, flush by bit 4, latch while masked
        edg = 1'b1; tick(); edg = 1'b0; tick();
        chk("R9 latched", status[6], 1);
        mask_write(8'h10);
        chk("R9 flushed", status[6], 0);
        chk("R9 masks kept", status[2:0], 3'b000);
        mask_write(8'h0C);
        edg = 1'b1; tick(); edg = 1'b0; tick();
        chk("R9 latched masked", status[6], 1);
        pulse_en();
        do_sample();
        chk("R9 masked no take", take, 0);
        mask_write(8'h08);
        do_sample();
        chk("R9 take", take, 1);
        chk("R9 vec", vec, 16'h003C);
        chk("R9 cleared on take", status[6], 0);

        // R10 dropped level not taken; R5 high level over low level
        pulse_en();
        lva = 1'b1; tick(); lva = 1'b0;
        do_sample();
        chk("R10 dropped", take, 0);
        lva = 1'b1; lvb = 1'b1; tick();
        do_sample();
        chk("R5 lva wins", vec, 16'h0034);
        lva = 1'b0; lvb = 1'b0; tick();

        // R5 R6 R11 sweep over masks and request combinations
        for (int m = 0; m < 8; m++) begin
            for (int r = 0; r < 32; r++) begin
                logic [4:0]  el;
                int          win;
                logic [15:0] ev;
                logic [7:0]  es;
                nmi = 0; edg = 0; lva = 0; lvb = 0; ext = 0; tick();
                mask_write(8'h18 | 8'(m));
                pulse_en();
                nmi = r[0]; edg = r[1]; lva = r[2]; lvb = r[3]; ext = r[4]; tick();
                edg = 1'b0;
                do_sample();
                el = {r[4] == 1, r[3] && !m[0], r[2] && !m[1], r[1] && !m[2], r[0] == 1};
                win = -1;
                for (int i = 4; i >= 0; i--) if (el[i]) win = i;
                case (win)
                    0: ev = 16'h0024;
                    1: ev = 16'h003C;
                    2: ev = 16'h0034;
                    3: ev = 16'h002C;
                    default: ev = 16'h0000;
                endcase
                es = {1'b0, (r[1] == 1) && (win != 1), r[2] == 1, r[3] == 1,
                      win < 0, 3'(m)};
                chk("R5 take", take, win >= 0);
                chk("R6 vector", vec, ev);
                chk("R6 novec", novec, win == 4);
                chk("R11 status", status, es);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule